// File: doc/BRIEF.md
# PLL Reprogramming Sequencer

This block changes the divider settings of one of several integer-mode PLLs without ever giving downstream logic an unstable clock. A request is a single-cycle `start` with a PLL index and four divider values: reference, feedback, first post and second post. The sequencer latches the request and checks it against the legal VCO and output windows. If the request passes, the sequencer moves the selected PLL's output source to the 24 MHz crystal and enables integer mode (delta-sigma modulation off). It then powers the PLL down, loads both divider words, powers it up again and waits for lock. Only after lock does it move the source back to the PLL.

The states are IDLE, CHECK, PARK, INTMODE, PWRDN, LOAD, PWRUP, LOCKWAIT, SWITCH and FAULT. The transitions are:

- IDLE→CHECK when `start` arrives.
- CHECK→PARK if the request is legal, CHECK→FAULT if it is not.
- PARK→INTMODE→PWRDN→LOAD→PWRUP→LOCKWAIT, one cycle each.
- LOCKWAIT→SWITCH when the selected PLL reports lock, LOCKWAIT→FAULT when the lock window runs out.
- SWITCH→IDLE with a `done` pulse.
- FAULT→IDLE with an `err` pulse.

Every PLL has a 2-bit source field in a shared select vector. PLL i owns bits [2i+1:2i]. A combinational read-back port reports the current output rate of any PLL from its source field and its stored dividers.

Top module: `pll_reprog_seq`

## Requirements
- R1: After reset, `busy`, `done`, `err`, `pwr_down` and `int_mode` are 0 and `src_sel` equals the `SRC_RST` parameter. The default gives PLL3 code 2, PLL4 code 3 and all others code 0.
- R2: A request is rejected in any of these cases:
  - the index is not below NUM_PLL;
  - any divider is zero;
  - the feedback divider is outside 16..3200;
  - 24·FB/REF is outside 800..3200 MHz;
  - 24·FB/(REF·P1·P2) is outside 24..3200 MHz.

  A rejected request gives an `err` pulse with `err_code` = 1 after the third clock edge counted from the start edge. It changes no PLL output.
- R3: For the selected PLL the outputs change in this order: source field to crystal (code 0), then `int_mode` set, then `pwr_down` set, then divider load, then `pwr_down` cleared. At most one PLL is powered down at a time.
- R4: The divider words for PLL i are `div_word0` = {P1, FB} and `div_word1` = {P2, REF}. They sit at word offset i, are written only while that PLL is powered down, and are written only for the selected PLL.
- R5: After power-up the sequencer moves the source field to the PLL (code 1) only after it has sampled lock. It then pulses `done` for one cycle, in the same cycle that `busy` falls.
- R6: If lock is not seen within LOCK_TIMEOUT cycles, `err` pulses with `err_code` = 2 after edge 8+LOCK_TIMEOUT, and the source field stays on the crystal.
- R7: `busy` is high from the edge after an accepted `start` until completion. A `start` while busy is ignored.
- R8: `rate_hz` for PLL `rate_idx` is:
  - code 0: 24000000;
  - code 1: (24·FB/(REF·P1·P2))·1000000, using integer division;
  - code 2, code 3 or an index of NUM_PLL or above: 32768.
- R9: A sequence changes only the source field of the selected PLL.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request pulse |
| req_idx | input | IDX_W | Target PLL index |
| req_refdiv | input | REF_W | Reference divider |
| req_fbdiv | input | FB_W | Feedback divider |
| req_pdiv1 | input | PD_W | First post-divider |
| req_pdiv2 | input | PD_W | Second post-divider |
| pll_lock | input | NUM_PLL | Lock indication per PLL |
| rate_idx | input | IDX_W | PLL index for rate read-back |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Success pulse |
| err | output | 1 | Failure pulse |
| err_code | output | 2 | 0 none, 1 illegal request, 2 lock timeout |
| src_sel | output | 2·NUM_PLL | Output source field per PLL |
| int_mode | output | NUM_PLL | Integer-mode enable per PLL |
| pwr_down | output | NUM_PLL | Power-down per PLL |
| div_word0 | output | NUM_PLL·(PD_W+FB_W) | {P1, FB} per PLL |
| div_word1 | output | NUM_PLL·(PD_W+REF_W) | {P2, REF} per PLL |
| rate_hz | output | 32 | Read-back rate of PLL `rate_idx` |

## Verification
A rejected request must show `err` three clock edges after the start edge. A lock timeout must show `err` after 8+LOCK_TIMEOUT edges. The bench counts falling edges from the start edge and compares that count exactly. A successful sequence depends on the lock model's delay, so the bench waits for `done` within a bound. It then samples `src_sel`, the divider words and `rate_hz` half a cycle after the edge that ended the sequence. Rate read-back is combinational: it is sampled 1 ns after `rate_idx` changes, with the clock low.

// File: rtl/pll_seq_pkg.sv
package pll_seq_pkg;
    typedef enum logic [3:0] {
        S_IDLE, S_CHECK, S_PARK, S_INTMODE, S_PWRDN,
        S_LOAD, S_PWRUP, S_LOCKWAIT, S_SWITCH, S_FAULT
    } seq_state_t;

    localparam logic [1:0] SRC_XTAL = 2'd0;
    localparam logic [1:0] SRC_PLL  = 2'd1;
    localparam logic [1:0] SRC_RTC  = 2'd2;

    localparam logic [1:0] ERR_NONE = 2'd0;
    localparam logic [1:0] ERR_CFG  = 2'd1;
    localparam logic [1:0] ERR_LOCK = 2'd2;

    localparam int unsigned XTAL_MHZ    = 24;
    localparam int unsigned XTAL_HZ     = 24_000_000;
    localparam int unsigned RTC_HZ      = 32_768;
    localparam int unsigned VCO_MIN_MHZ = 800;
    localparam int unsigned VCO_MAX_MHZ = 3200;
    localparam int unsigned OUT_MIN_MHZ = 24;
    localparam int unsigned OUT_MAX_MHZ = 3200;
    localparam int unsigned FB_MIN      = 16;
    localparam int unsigned FB_MAX      = 3200;
endpackage

// File: rtl/pll_cfg_check.sv
module pll_cfg_check import pll_seq_pkg::*; #(
    parameter int NUM_PLL = 5,
    parameter int IDX_W   = 3,
    parameter int REF_W   = 6,
    parameter int FB_W    = 12,
    parameter int PD_W    = 3
) (
    input  logic [IDX_W-1:0] idx,
    input  logic [REF_W-1:0] refdiv,
    input  logic [FB_W-1:0]  fbdiv,
    input  logic [PD_W-1:0]  pdiv1,
    input  logic [PD_W-1:0]  pdiv2,
    output logic             cfg_ok
);
    logic [31:0] fb_mhz, ref32, div_all;
    logic idx_ok, nz_ok, fb_ok, vco_ok, out_ok;

    always_comb begin
        fb_mhz  = 32'(fbdiv) * XTAL_MHZ;
        ref32   = 32'(refdiv);
        div_all = ref32 * 32'(pdiv1) * 32'(pdiv2);
        idx_ok  = 32'(idx) < NUM_PLL;
        nz_ok   = (refdiv != '0) && (pdiv1 != '0) && (pdiv2 != '0);
        fb_ok   = (32'(fbdiv) >= FB_MIN) && (32'(fbdiv) <= FB_MAX);
        vco_ok  = (fb_mhz >= VCO_MIN_MHZ * ref32) && (fb_mhz <= VCO_MAX_MHZ * ref32);
        out_ok  = (fb_mhz >= OUT_MIN_MHZ * div_all) && (fb_mhz <= OUT_MAX_MHZ * div_all);
        cfg_ok  = idx_ok && nz_ok && fb_ok && vco_ok && out_ok;
    end
endmodule

// File: rtl/pll_rate_calc.sv
module pll_rate_calc import pll_seq_pkg::*; #(
    parameter int REF_W = 6,
    parameter int FB_W  = 12,
    parameter int PD_W  = 3
) (
    input  logic [1:0]       src_code,
    input  logic [REF_W-1:0] refdiv,
    input  logic [FB_W-1:0]  fbdiv,
    input  logic [PD_W-1:0]  pdiv1,
    input  logic [PD_W-1:0]  pdiv2,
    output logic [31:0]      rate_hz
);
    logic [31:0] div_all, quot;

    always_comb begin
        div_all = 32'(refdiv) * 32'(pdiv1) * 32'(pdiv2);
        quot    = (div_all == '0) ? '0 : (32'(fbdiv) * XTAL_MHZ) / div_all;
        unique case (src_code)
            SRC_XTAL: rate_hz = XTAL_HZ;
            SRC_PLL:  rate_hz = quot * 32'd1_000_000;
            default:  rate_hz = RTC_HZ;
        endcase
    end
endmodule

// File: rtl/pll_slot.sv
module pll_slot import pll_seq_pkg::*; #(
    parameter int         REF_W   = 6,
    parameter int         FB_W    = 12,
    parameter int         PD_W    = 3,
    parameter logic [1:0] SRC_INI = SRC_XTAL,
    localparam int        C0_W    = PD_W + FB_W,
    localparam int        C1_W    = PD_W + REF_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sel,
    input  logic             do_park,
    input  logic             do_int,
    input  logic             do_pd,
    input  logic             do_load,
    input  logic             do_pu,
    input  logic             do_sw,
    input  logic [REF_W-1:0] refdiv,
    input  logic [FB_W-1:0]  fbdiv,
    input  logic [PD_W-1:0]  pdiv1,
    input  logic [PD_W-1:0]  pdiv2,
    output logic [1:0]       src,
    output logic             int_en,
    output logic             pd,
    output logic [C0_W-1:0]  word0,
    output logic [C1_W-1:0]  word1
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            src    <= SRC_INI;
            int_en <= 1'b0;
            pd     <= 1'b0;
            word0  <= '0;
            word1  <= '0;
        end else if (sel) begin
            if (do_park) src    <= SRC_XTAL;
            if (do_sw)   src    <= SRC_PLL;
            if (do_int)  int_en <= 1'b1;
            if (do_pd)   pd     <= 1'b1;
            if (do_pu)   pd     <= 1'b0;
            if (do_load) begin
                word0 <= {pdiv1, fbdiv};
                word1 <= {pdiv2, refdiv};
            end
        end
    end
endmodule

// File: rtl/pll_seq_ctrl.sv
module pll_seq_ctrl import pll_seq_pkg::*; #(
    parameter int IDX_W        = 3,
    parameter int REF_W        = 6,
    parameter int FB_W         = 12,
    parameter int PD_W         = 3,
    parameter int LOCK_TIMEOUT = 1000,
    localparam int CNT_W       = $clog2(LOCK_TIMEOUT + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [IDX_W-1:0] req_idx,
    input  logic [REF_W-1:0] req_refdiv,
    input  logic [FB_W-1:0]  req_fbdiv,
    input  logic [PD_W-1:0]  req_pdiv1,
    input  logic [PD_W-1:0]  req_pdiv2,
    input  logic             cfg_ok,
    input  logic             lock_sel,
    output logic             busy,
    output logic             done,
    output logic             err,
    output logic [1:0]       err_code,
    output logic [IDX_W-1:0] tgt_idx,
    output logic [REF_W-1:0] lat_ref,
    output logic [FB_W-1:0]  lat_fb,
    output logic [PD_W-1:0]  lat_pd1,
    output logic [PD_W-1:0]  lat_pd2,
    output logic             do_park,
    output logic             do_int,
    output logic             do_pd,
    output logic             do_load,
    output logic             do_pu,
    output logic             do_sw
);
    seq_state_t state, nxt;
    logic [CNT_W-1:0] wait_cnt;
    logic lock_expired;

    assign lock_expired = (wait_cnt == CNT_W'(LOCK_TIMEOUT - 1));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE:     if (start) nxt = S_CHECK;
            S_CHECK:    nxt = cfg_ok ? S_PARK : S_FAULT;
            S_PARK:     nxt = S_INTMODE;
            S_INTMODE:  nxt = S_PWRDN;
            S_PWRDN:    nxt = S_LOAD;
            S_LOAD:     nxt = S_PWRUP;
            S_PWRUP:    nxt = S_LOCKWAIT;
            S_LOCKWAIT: begin
                if (lock_sel)          nxt = S_SWITCH;
                else if (lock_expired) nxt = S_FAULT;
            end
            S_SWITCH:   nxt = S_IDLE;
            S_FAULT:    nxt = S_IDLE;
            default:    nxt = S_IDLE;
        endcase
    end

    // registered outputs and request latch
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done     <= 1'b0;
            err      <= 1'b0;
            err_code <= ERR_NONE;
            wait_cnt <= '0;
            tgt_idx  <= '0;
            lat_ref  <= '0;
            lat_fb   <= '0;
            lat_pd1  <= '0;
            lat_pd2  <= '0;
        end else begin
            done <= (state == S_SWITCH);
            err  <= (state == S_FAULT);
            unique case (state)
                S_IDLE: if (start) begin
                    err_code <= ERR_NONE;
                    tgt_idx  <= req_idx;
                    lat_ref  <= req_refdiv;
                    lat_fb   <= req_fbdiv;
                    lat_pd1  <= req_pdiv1;
                    lat_pd2  <= req_pdiv2;
                end
                S_CHECK:    if (!cfg_ok) err_code <= ERR_CFG;
                S_PWRUP:    wait_cnt <= '0;
                S_LOCKWAIT: begin
                    wait_cnt <= wait_cnt + 1'b1;
                    if (!lock_sel && lock_expired) err_code <= ERR_LOCK;
                end
                default: ;
            endcase
        end
    end

    assign busy    = (state != S_IDLE);
    assign do_park = (state == S_PARK);
    assign do_int  = (state == S_INTMODE);
    assign do_pd   = (state == S_PWRDN);
    assign do_load = (state == S_LOAD);
    assign do_pu   = (state == S_PWRUP);
    assign do_sw   = (state == S_SWITCH);
endmodule

// File: rtl/pll_reprog_seq.sv
module pll_reprog_seq import pll_seq_pkg::*; #(
    parameter int                     NUM_PLL      = 5,
    parameter int                     REF_W        = 6,
    parameter int                     FB_W         = 12,
    parameter int                     PD_W         = 3,
    parameter int                     LOCK_TIMEOUT = 1000,
    parameter logic [2*NUM_PLL-1:0]   SRC_RST      = 10'b11_10_00_00_00
) (
    input  logic                                          clk,
    input  logic                                          rst_n,
    input  logic                                          start,
    input  logic [(NUM_PLL > 1 ? $clog2(NUM_PLL) : 1)-1:0] req_idx,
    input  logic [REF_W-1:0]                              req_refdiv,
    input  logic [FB_W-1:0]                               req_fbdiv,
    input  logic [PD_W-1:0]                               req_pdiv1,
    input  logic [PD_W-1:0]                               req_pdiv2,
    input  logic [NUM_PLL-1:0]                            pll_lock,
    input  logic [(NUM_PLL > 1 ? $clog2(NUM_PLL) : 1)-1:0] rate_idx,
    output logic                                          busy,
    output logic                                          done,
    output logic                                          err,
    output logic [1:0]                                    err_code,
    output logic [2*NUM_PLL-1:0]                          src_sel,
    output logic [NUM_PLL-1:0]                            int_mode,
    output logic [NUM_PLL-1:0]                            pwr_down,
    output logic [NUM_PLL*(PD_W+FB_W)-1:0]                div_word0,
    output logic [NUM_PLL*(PD_W+REF_W)-1:0]               div_word1,
    output logic [31:0]                                   rate_hz
);
    localparam int IDX_W = (NUM_PLL > 1) ? $clog2(NUM_PLL) : 1;
    localparam int SLOTS = 1 << IDX_W;
    localparam int C0_W  = PD_W + FB_W;
    localparam int C1_W  = PD_W + REF_W;

    logic [IDX_W-1:0] tgt_idx;
    logic [REF_W-1:0] lat_ref;
    logic [FB_W-1:0]  lat_fb;
    logic [PD_W-1:0]  lat_pd1, lat_pd2;
    logic cfg_ok, lock_sel;
    logic do_park, do_int, do_pd, do_load, do_pu, do_sw;
    logic [SLOTS-1:0] lock_pad;

    logic [1:0]      src_a   [SLOTS];
    logic [C0_W-1:0] word0_a [SLOTS];
    logic [C1_W-1:0] word1_a [SLOTS];

    assign lock_pad = SLOTS'(pll_lock);
    assign lock_sel = lock_pad[tgt_idx];

    pll_cfg_check #(.NUM_PLL(NUM_PLL), .IDX_W(IDX_W), .REF_W(REF_W),
                    .FB_W(FB_W), .PD_W(PD_W)) u_check (
        .idx(tgt_idx), .refdiv(lat_ref), .fbdiv(lat_fb),
        .pdiv1(lat_pd1), .pdiv2(lat_pd2), .cfg_ok(cfg_ok)
    );

    pll_seq_ctrl #(.IDX_W(IDX_W), .REF_W(REF_W), .FB_W(FB_W), .PD_W(PD_W),
                   .LOCK_TIMEOUT(LOCK_TIMEOUT)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start),
        .req_idx(req_idx), .req_refdiv(req_refdiv), .req_fbdiv(req_fbdiv),
        .req_pdiv1(req_pdiv1), .req_pdiv2(req_pdiv2),
        .cfg_ok(cfg_ok), .lock_sel(lock_sel),
        .busy(busy), .done(done), .err(err), .err_code(err_code),
        .tgt_idx(tgt_idx), .lat_ref(lat_ref), .lat_fb(lat_fb),
        .lat_pd1(lat_pd1), .lat_pd2(lat_pd2),
        .do_park(do_park), .do_int(do_int), .do_pd(do_pd),
        .do_load(do_load), .do_pu(do_pu), .do_sw(do_sw)
    );

    for (genvar i = 0; i < SLOTS; i++) begin : g_slot
        if (i < NUM_PLL) begin : g_real
            pll_slot #(.REF_W(REF_W), .FB_W(FB_W), .PD_W(PD_W),
                       .SRC_INI(SRC_RST[2*i +: 2])) u_slot (
                .clk(clk), .rst_n(rst_n), .sel(tgt_idx == IDX_W'(i)),
                .do_park(do_park), .do_int(do_int), .do_pd(do_pd),
                .do_load(do_load), .do_pu(do_pu), .do_sw(do_sw),
                .refdiv(lat_ref), .fbdiv(lat_fb), .pdiv1(lat_pd1), .pdiv2(lat_pd2),
                .src(src_a[i]), .int_en(int_mode[i]), .pd(pwr_down[i]),
                .word0(word0_a[i]), .word1(word1_a[i])
            );
            assign src_sel[2*i +: 2]      = src_a[i];
            assign div_word0[i*C0_W +: C0_W] = word0_a[i];
            assign div_word1[i*C1_W +: C1_W] = word1_a[i];
        end else begin : g_pad
            assign src_a[i]   = 2'b11;
            assign word0_a[i] = '0;
            assign word1_a[i] = '0;
        end
    end

    pll_rate_calc #(.REF_W(REF_W), .FB_W(FB_W), .PD_W(PD_W)) u_rate (
        .src_code(src_a[rate_idx]),
        .refdiv(word1_a[rate_idx][REF_W-1:0]),
        .fbdiv(word0_a[rate_idx][FB_W-1:0]),
        .pdiv1(word0_a[rate_idx][C0_W-1 -: PD_W]),
        .pdiv2(word1_a[rate_idx][C1_W-1 -: PD_W]),
        .rate_hz(rate_hz)
    );
endmodule

// File: rtl/pll_reprog_seq_chk.sv
module pll_reprog_seq_chk import pll_seq_pkg::*; #(
    parameter int NUM_PLL = 5,
    parameter int REF_W   = 6,
    parameter int FB_W    = 12,
    parameter int PD_W    = 3,
    localparam int C0_W   = PD_W + FB_W,
    localparam int C1_W   = PD_W + REF_W
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic                         start,
    input logic                         busy,
    input logic                         done,
    input logic                         err,
    input logic [1:0]                   err_code,
    input logic [NUM_PLL-1:0]           pll_lock,
    input logic [2*NUM_PLL-1:0]         src_sel,
    input logic [NUM_PLL-1:0]           int_mode,
    input logic [NUM_PLL-1:0]           pwr_down,
    input logic [NUM_PLL*C0_W-1:0]      div_word0,
    input logic [NUM_PLL*C1_W-1:0]      div_word1
);
    AST_PD_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(pwr_down)); // R3
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy && !err && err_code == ERR_NONE)); // R5
    AST_ERR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (!busy && err_code != ERR_NONE)); // R6
    AST_BUSY_ON_START: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy); // R7

    for (genvar i = 0; i < NUM_PLL; i++) begin : g_pll
        AST_PARK_BEFORE_PD: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(pwr_down[i]) |-> (src_sel[2*i +: 2] == SRC_XTAL && int_mode[i])); // R3
        AST_LOAD_IN_PD: assert property (@(posedge clk) disable iff (!rst_n)
            (!$stable(div_word0[i*C0_W +: C0_W]) || !$stable(div_word1[i*C1_W +: C1_W]))
            |-> pwr_down[i]); // R4
        AST_SWITCH_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
            (src_sel[2*i +: 2] == SRC_PLL && $past(src_sel[2*i +: 2]) != SRC_PLL)
            |-> ($past(pll_lock[i]) && !pwr_down[i])); // R5
    end
endmodule

bind pll_reprog_seq pll_reprog_seq_chk #(
    .NUM_PLL(NUM_PLL), .REF_W(REF_W), .FB_W(FB_W), .PD_W(PD_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
    .err(err), .err_code(err_code), .pll_lock(pll_lock), .src_sel(src_sel),
    .int_mode(int_mode), .pwr_down(pwr_down),
    .div_word0(div_word0), .div_word1(div_word1)
);

// File: tb/tb_pll_reprog_seq.sv
module tb_pll_reprog_seq;
    localparam int NUM_PLL = 5;
    localparam int REF_W = 6, FB_W = 12, PD_W = 3;
    localparam int IDX_W = 3;
    localparam int TMO = 40;
    localparam int LOCK_DLY = 5;
    localparam int C0_W = PD_W + FB_W;
    localparam logic [2*NUM_PLL-1:0] RST_SRC = 10'b11_10_00_00_00;

    logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
    logic [IDX_W-1:0] req_idx = '0, rate_idx = '0;
    logic [REF_W-1:0] req_refdiv = '0;
    logic [FB_W-1:0]  req_fbdiv = '0;
    logic [PD_W-1:0]  req_pdiv1 = '0, req_pdiv2 = '0;
    logic [NUM_PLL-1:0] pll_lock;
    logic busy, done, err;
    logic [1:0] err_code;
    logic [2*NUM_PLL-1:0] src_sel;
    logic [NUM_PLL-1:0] int_mode, pwr_down;
    logic [NUM_PLL*C0_W-1:0] div_word0;
    logic [NUM_PLL*(PD_W+REF_W)-1:0] div_word1;
    logic [31:0] rate_hz;

    int checks = 0, fails = 0;
    int lk_cnt [NUM_PLL];
    bit broken [NUM_PLL];
    logic [2*NUM_PLL-1:0] shadow;

    always #5 clk = ~clk;

    pll_reprog_seq #(.NUM_PLL(NUM_PLL), .REF_W(REF_W), .FB_W(FB_W), .PD_W(PD_W),
                     .LOCK_TIMEOUT(TMO), .SRC_RST(RST_SRC)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .req_idx(req_idx),
        .req_refdiv(req_refdiv), .req_fbdiv(req_fbdiv), .req_pdiv1(req_pdiv1),
        .req_pdiv2(req_pdiv2), .pll_lock(pll_lock), .rate_idx(rate_idx),
        .busy(busy), .done(done), .err(err), .err_code(err_code),
        .src_sel(src_sel), .int_mode(int_mode), .pwr_down(pwr_down),
        .div_word0(div_word0), .div_word1(div_word1), .rate_hz(rate_hz)
    );

    // analog PLL model: lock drops in power-down, returns LOCK_DLY cycles after
    always @(posedge clk) begin
        for (int i = 0; i < NUM_PLL; i++) begin
            if (!rst_n) lk_cnt[i] <= LOCK_DLY;
            else if (pwr_down[i] || broken[i]) lk_cnt[i] <= 0;
            else if (lk_cnt[i] < LOCK_DLY) lk_cnt[i] <= lk_cnt[i] + 1;
        end
    end
    always @* begin
        for (int i = 0; i < NUM_PLL; i++) pll_lock[i] = (lk_cnt[i] >= LOCK_DLY);
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic report();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    endtask

    function automatic longint rd_rate(input int idx);
        return 0;
    endfunction

    task automatic get_rate(input int idx, output longint r);
        rate_idx = IDX_W'(idx);
        #1;
        r = rate_hz;
    endtask

    function automatic bit legal(input int idx, input int r, input int f, input int p1, input int p2);
        longint fm = 24 * f;
        longint da = r * p1 * p2;
        return idx < NUM_PLL && r > 0 && p1 > 0 && p2 > 0 && f >= 16 && f <= 3200
            && fm >= 800 * r && fm <= 3200 * r && fm >= 24 * da && fm <= 3200 * da;
    endfunction

    task automatic run_req(input int idx, input int r, input int f, input int p1, input int p2,
                           output int n);
        @(negedge clk);
        start = 1'b1;
        req_idx = IDX_W'(idx); req_refdiv = REF_W'(r); req_fbdiv = FB_W'(f);
        req_pdiv1 = PD_W'(p1); req_pdiv2 = PD_W'(p2);
        @(negedge clk);
        start = 1'b0;
        n = 1;
        while (!(done || err) && n < 400) begin
            @(negedge clk);
            n++;
        end
    endtask

    function automatic int fb_pick(input int k);
        case (k)
            0: return 15;   1: return 16;   2: return 40;   3: return 100;
            4: return 134;  5: return 400;  6: return 3200; default: return 3201;
        endcase
    endfunction

    initial begin
        repeat (190000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        report();
    end

    initial begin
        int n, op;
        longint rt, exp_rt;
        foreach (broken[i]) broken[i] = 1'b0;
        shadow = RST_SRC;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk(!busy && !done && !err, "R1 idle flags", {busy, done, err}, 0);
        chk(pwr_down == '0 && int_mode == '0, "R1 pd/int", {pwr_down, int_mode}, 0);
        chk(src_sel == RST_SRC, "R1 src_sel", src_sel, RST_SRC);
        // R8 decode of crystal, RTC, unknown code, out-of-range index
        get_rate(0, rt); chk(rt == 24000000, "R8 crystal", rt, 24000000);
        get_rate(3, rt); chk(rt == 32768, "R8 rtc", rt, 32768);
        get_rate(4, rt); chk(rt == 32768, "R8 unknown code", rt, 32768);
        get_rate(7, rt); chk(rt == 32768, "R8 index beyond", rt, 32768);

        // near-exhaustive sweep over small divider ranges
        op = 0;
        for (int r = 0; r < 8; r++)
            for (int p1 = 0; p1 < 8; p1++)
                for (int p2 = 0; p2 < 8; p2++)
                    for (int k = 0; k < 8; k++) begin
                        int f = fb_pick(k);
                        int idx = op % NUM_PLL;
                        op++;
                        run_req(idx, r, f, p1, p2, n);
                        if (legal(idx, r, f, p1, p2)) begin
                            chk(done && !err && !busy && n < 40, "R5 done", {done, err}, 2);
                            shadow[2*idx +: 2] = 2'd1;
                            chk(int_mode[idx], "R3 int_mode", int_mode[idx], 1);
                            chk(div_word0[idx*C0_W +: C0_W] == {PD_W'(p1), FB_W'(f)}, "R4 word0",
                                div_word0[idx*C0_W +: C0_W], {PD_W'(p1), FB_W'(f)});
                            chk(div_word1[idx*9 +: 9] == {PD_W'(p2), REF_W'(r)}, "R4 word1",
                                div_word1[idx*9 +: 9], {PD_W'(p2), REF_W'(r)});
                            exp_rt = (longint'(24 * f) / (r * p1 * p2)) * 1000000;
                            get_rate(idx, rt);
                            chk(rt == exp_rt, "R8 pll rate", rt, exp_rt);
                        end else begin
                            chk(err && !done && n == 3 && err_code == 2'd1, "R2 reject",
                                n * 10 + err_code, 31);
                        end
                        chk(src_sel == shadow, "R9 fields", src_sel, shadow);
                    end

        // R2 index out of range with otherwise legal dividers
        run_req(6, 1, 100, 2, 1, n);
        chk(err && n == 3 && err_code == 2'd1, "R2 bad index", n * 10 + err_code, 31);
        chk(src_sel == shadow, "R2 no change", src_sel, shadow);

        // R6 lock timeout on PLL2
        broken[2] = 1'b1;
        run_req(2, 1, 100, 2, 1, n);
        chk(err && n == 8 + TMO && err_code == 2'd2, "R6 timeout", n * 10 + err_code, (8 + TMO) * 10 + 2);
        chk(src_sel[5:4] == 2'd0, "R6 parked", src_sel[5:4], 0);
        get_rate(2, rt); chk(rt == 24000000, "R6 rate crystal", rt, 24000000);
        shadow[5:4] = 2'd0;
        broken[2] = 1'b0;
        repeat (LOCK_DLY + 2) @(negedge clk);
        run_req(2, 1, 100, 2, 1, n);
        chk(done && err_code == 2'd0, "R5 recover", err_code, 0);
        shadow[5:4] = 2'd1;

        // R7 start while busy is ignored
        @(negedge clk);
        start = 1'b1; req_idx = 3'd1; req_refdiv = 6'd1; req_fbdiv = 12'd50;
        req_pdiv1 = 3'd1; req_pdiv2 = 3'd1;
        @(negedge clk); start = 1'b0;
        @(negedge clk);
        chk(busy, "R7 busy", busy, 1);
        start = 1'b1; req_idx = 3'd0; req_fbdiv = 12'd15;
        @(negedge clk); start = 1'b0;
        n = 0;
        while (!done && n < 100) begin
            chk(!err, "R7 no err", err, 0);
            @(negedge clk); n++;
        end
        chk(done, "R7 first done", done, 1);
        shadow[3:2] = 2'd1;
        repeat (8) begin
            @(negedge clk);
            chk(!busy && !err && !done, "R7 ignored", {busy, err, done}, 0);
        end
        chk(src_sel == shadow, "R7 fields", src_sel, shadow);
        get_rate(1, rt); chk(rt == 64'd1200000000, "R7 rate", rt, 1200000000);

        report();
    end
endmodule